// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital side of a 12-bit successive-approximation converter. It accepts a start request from one of four sources, chosen by a 2-bit field. It divides the system clock down to a bit clock with a 5-bit prescaler. It then resolves the result one bit per bit-clock tick. Each tick it drives a trial code to an external DAC and reads back a single comparator bit.

While a conversion runs, a busy output is high. When busy drops, a sticky end-of-conversion flag is set. That flag raises an interrupt request when interrupts are enabled, and it stays set until software clears it. The finished code goes into a 16-bit data word. In single-ended mode the code is unsigned; in differential mode it is two's complement. It can be placed at the low end or the high end of the word. The comparator, the DAC, the register bus and all analog parts sit outside this block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy, the end-of-conversion flag, irq, data_word and dac_code are all 0.
- R2: start_sel picks the trigger. 0 accepts a sw_start pulse, 1 accepts tmr2_ovf, 2 accepts tmr3_ovf, and 3 accepts a rising edge of ext_start. ext_start passes through two synchronizer flops, so its edge is accepted on the third rising clock edge after it goes high. Sources that are not selected are ignored.
- R3: An accepted trigger sets busy on the next clock edge. Busy then stays high for exactly 12*(clk_div+1) cycles, where clk_div is sampled when the trigger is accepted.
- R4: eoc_flag is set on the clock edge at which busy falls. It holds until an eoc_clear pulse. irq equals eoc_flag AND irq_en.
- R5: With diff_mode=0 the result is unsigned, from 0x000 to 0xFFF. A comparator that always answers "at or above" gives 0xFFF.
- R6: With diff_mode=1 the trial and result codes are offset binary, and the reported code is two's complement with the MSB inverted. The range runs from -2048 (0xF800 right-justified) to 2047 (0x07FF). Inputs beyond either end saturate.
- R7: With justify=0 the code sits in data_word[11:0], with bits 15:12 zero in single-ended mode and sign copies in differential mode. With justify=1 the code sits in data_word[15:4] and bits 3:0 are zero.
- R8: While enable=0, triggers are ignored: busy stays 0 and eoc_flag does not change.
- R9: A trigger that arrives while busy=1 is ignored. The running conversion keeps its length and its result.
- R10: The first trial code is 0x800. On each tick, the bit under test is kept when cmp_in=1, and the next lower bit is set.
- R11: data_word changes only on the edge where busy falls. During a conversion it keeps the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable |
| start_sel | input | 2 | Trigger source select |
| sw_start | input | 1 | Software start pulse |
| tmr2_ovf | input | 1 | Timer-2 overflow pulse |
| tmr3_ovf | input | 1 | Timer-3 overflow pulse |
| ext_start | input | 1 | Asynchronous external convert-start |
| clk_div | input | 5 | Bit clock = clk/(clk_div+1) |
| diff_mode | input | 1 | 1: differential, two's complement result |
| justify | input | 1 | 1: left-justified data word |
| irq_en | input | 1 | Interrupt enable |
| eoc_clear | input | 1 | Clears the end-of-conversion flag |
| cmp_in | input | 1 | Comparator: input at or above dac_code |
| dac_code | output | 12 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| eoc_flag | output | 1 | Sticky end-of-conversion flag |
| irq | output | 1 | Interrupt request |
| data_word | output | 16 | Formatted result |

## Verification
A pulse trigger that is high at clock edge P0 is accepted there, so busy is expected high at the falling edge after P0. An external start needs two more edges for synchronization. Busy is expected high at the falling edge after P0+L-1 and low at the one after P0+L, where L=12*(clk_div+1). eoc_flag and the new data_word are checked at that same falling edge. The bench counts falling edges from the accepting edge and samples only there. The second trial code is checked after clk_div+1 cycles. A mid-conversion retrigger is applied and the data word is read at that point.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    SRC_SOFT = 2'd0,
    SRC_TMR2 = 2'd1,
    SRC_TMR3 = 2'd2,
    SRC_EXT  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/sar_trigger.sv
module sar_trigger (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] start_sel,
  input  logic       sw_start,
  input  logic       tmr2_ovf,
  input  logic       tmr3_ovf,
  input  logic       ext_start,
  output logic       trig
);
  import sar_pkg::*;

  logic ext_s1_q, ext_s2_q, ext_s3_q;
  logic ext_rise;
  src_sel_e sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s1_q <= 1'b0;
      ext_s2_q <= 1'b0;
      ext_s3_q <= 1'b0;
    end else begin
      ext_s1_q <= ext_start;
      ext_s2_q <= ext_s1_q;
      ext_s3_q <= ext_s2_q;
    end
  end

  assign ext_rise = ext_s2_q & ~ext_s3_q;
  assign sel      = src_sel_e'(start_sel);

  always_comb begin
    unique case (sel)
      SRC_SOFT: trig = sw_start;
      SRC_TMR2: trig = tmr2_ovf;
      SRC_TMR3: trig = tmr3_ovf;
      SRC_EXT:  trig = ext_rise;
      default:  trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, div_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             wrap;

  assign wrap = (cnt_q == div_q);
  assign tick = run & wrap;

  always_comb begin
    div_n = div_q;
    cnt_n = cnt_q;
    if (load) begin
      div_n = div_in;
      cnt_n = '0;
    end else if (run) begin
      cnt_n = wrap ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           tick,
  input  logic           cmp_in,
  output logic           busy,
  output logic [RES-1:0] trial,
  output logic           done,
  output logic [RES-1:0] final_code
);
  localparam int IDX_W = $clog2(RES);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES - 1);
  localparam logic [RES-1:0]   MSB_MASK = {1'b1, {(RES-1){1'b0}}};

  logic             busy_q, busy_n;
  logic [RES-1:0]   trial_q, trial_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [RES-1:0]   mask;
  logic [RES-1:0]   resolved;

  assign mask     = RES'(1) << idx_q;
  assign resolved = cmp_in ? trial_q : (trial_q & ~mask);

  always_comb begin
    busy_n  = busy_q;
    trial_n = trial_q;
    idx_n   = idx_q;
    done    = 1'b0;
    if (start) begin
      busy_n  = 1'b1;
      trial_n = MSB_MASK;
      idx_n   = TOP_IDX;
    end else if (busy_q && tick) begin
      if (idx_q == '0) begin
        done    = 1'b1;
        busy_n  = 1'b0;
        trial_n = resolved;
      end else begin
        trial_n = resolved | (mask >> 1);
        idx_n   = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      trial_q <= '0;
      idx_q   <= '0;
    end else begin
      busy_q  <= busy_n;
      trial_q <= trial_n;
      idx_q   <= idx_n;
    end
  end

  assign busy       = busy_q;
  assign trial      = trial_q;
  assign final_code = resolved;
endmodule

// File: rtl/sar_format.sv
module sar_format #(
  parameter int RES  = 12,
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [RES-1:0]  code,
  input  logic            diff_mode,
  input  logic            justify,
  output logic [WORD-1:0] word
);
  localparam int PAD = WORD - RES;

  logic [RES-1:0]  conv_code;
  logic [WORD-1:0] right_w, left_w;
  logic [WORD-1:0] word_q, word_n;
  logic            ext_bit;

  assign conv_code = diff_mode ? {~code[RES-1], code[RES-2:0]} : code;
  assign ext_bit   = diff_mode & conv_code[RES-1];

  generate
    if (PAD > 0) begin : g_pad
      assign right_w = {{PAD{ext_bit}}, conv_code};
      assign left_w  = {conv_code, {PAD{1'b0}}};
    end else begin : g_nopad
      assign right_w = conv_code;
      assign left_w  = conv_code;
    end
  endgenerate

  always_comb begin
    word_n = word_q;
    if (load) word_n = justify ? left_w : right_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_n;
  end

  assign word = word_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int RES   = 12,
  parameter int WORD  = 16,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       start_sel,
  input  logic             sw_start,
  input  logic             tmr2_ovf,
  input  logic             tmr3_ovf,
  input  logic             ext_start,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             diff_mode,
  input  logic             justify,
  input  logic             irq_en,
  input  logic             eoc_clear,
  input  logic             cmp_in,
  output logic [RES-1:0]   dac_code,
  output logic             busy,
  output logic             eoc_flag,
  output logic             irq,
  output logic [WORD-1:0]  data_word
);
  logic rst_s1_q, rst_s2_q;
  logic trig, start, tick, done;
  logic [RES-1:0] final_code;
  logic eoc_q, eoc_n;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  sar_trigger u_trig (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .start_sel (start_sel),
    .sw_start  (sw_start),
    .tmr2_ovf  (tmr2_ovf),
    .tmr3_ovf  (tmr3_ovf),
    .ext_start (ext_start),
    .trig      (trig)
  );

  assign start = enable & ~busy & trig;

  sar_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .load   (start),
    .div_in (clk_div),
    .run    (busy),
    .tick   (tick)
  );

  sar_engine #(.RES(RES)) u_eng (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .start      (start),
    .tick       (tick),
    .cmp_in     (cmp_in),
    .busy       (busy),
    .trial      (dac_code),
    .done       (done),
    .final_code (final_code)
  );

  sar_format #(.RES(RES), .WORD(WORD)) u_fmt (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .load      (done),
    .code      (final_code),
    .diff_mode (diff_mode),
    .justify   (justify),
    .word      (data_word)
  );

  always_comb begin
    eoc_n = eoc_q;
    if (done)           eoc_n = 1'b1;
    else if (eoc_clear) eoc_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) eoc_q <= 1'b0;
    else           eoc_q <= eoc_n;
  end

  assign eoc_flag = eoc_q;
  assign irq      = eoc_q & irq_en;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int RES   = 12,
  parameter int WORD  = 16,
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [DIV_W-1:0] clk_div,
  input logic             eoc_clear,
  input logic [RES-1:0]   dac_code,
  input logic             busy,
  input logic             eoc_flag,
  input logic             irq,
  input logic [WORD-1:0]  data_word
);
  localparam logic [RES-1:0] MSB_CODE = {1'b1, {(RES-1){1'b0}}};

  logic [15:0]      len_q;
  logic [DIV_W-1:0] div_lat_q;
  logic [15:0]      len_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      div_lat_q <= '0;
    end else begin
      len_q <= busy ? len_q + 16'd1 : 16'd0;
      if (!busy) div_lat_q <= clk_div;
    end
  end

  assign len_exp = 16'(RES * (32'(div_lat_q) + 1));

  // R3
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == len_exp));

  // R4
  eoc_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eoc_flag);

  // R4
  eoc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_flag && !eoc_clear) |=> eoc_flag);

  // R4
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> eoc_flag);

  // R8
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable));

  // R10
  first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dac_code == MSB_CODE));

  // R10
  trial_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dac_code != '0));

  // R11
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(data_word));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES(RES), .WORD(WORD), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .clk_div   (clk_div),
  .eoc_clear (eoc_clear),
  .dac_code  (dac_code),
  .busy      (busy),
  .eoc_flag  (eoc_flag),
  .irq       (irq),
  .data_word (data_word)
);

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  start_sel = 2'd0;
  logic        sw_start = 1'b0, tmr2_ovf = 1'b0, tmr3_ovf = 1'b0, ext_start = 1'b0;
  logic [4:0]  clk_div = 5'd0;
  logic        diff_mode = 1'b0, justify = 1'b0, irq_en = 1'b0, eoc_clear = 1'b0;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic        busy, eoc_flag, irq;
  logic [15:0] data_word;

  int vin_code = 0;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [15:0] last_word = 16'h0000;

  always #4 clk = ~clk;

  assign cmp_in = (vin_code >= int'(dac_code));

  sar_conv_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_sel(start_sel),
    .sw_start(sw_start), .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf),
    .ext_start(ext_start), .clk_div(clk_div), .diff_mode(diff_mode),
    .justify(justify), .irq_en(irq_en), .eoc_clear(eoc_clear),
    .cmp_in(cmp_in), .dac_code(dac_code), .busy(busy), .eoc_flag(eoc_flag),
    .irq(irq), .data_word(data_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic logic [15:0] expect_word(input int vin, input bit d, input bit j);
    int c;
    logic [11:0] c12;
    c   = d ? clampi(vin, -2048, 2047) : clampi(vin, 0, 4095);
    c12 = c[11:0];
    if (j) return {c12, 4'b0000};
    return d ? {{4{c12[11]}}, c12} : {4'b0000, c12};
  endfunction

  task automatic fire(input int src);
    @(negedge clk);
    case (src)
      0: sw_start = 1'b1;
      1: tmr2_ovf = 1'b1;
      2: tmr3_ovf = 1'b1;
      default: begin
        ext_start = 1'b1;
        @(posedge clk);
        @(posedge clk);
      end
    endcase
  endtask

  task automatic drop_pulses;
    sw_start = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0;
  endtask

  task automatic clear_eoc;
    @(negedge clk);
    eoc_clear = 1'b1;
    @(negedge clk);
    eoc_clear = 1'b0;
    chk(eoc_flag == 1'b0, "R4", "eoc after clear", eoc_flag, 0);
  endtask

  // Full conversion with timing, trial code, hold and result checks
  task automatic convert(input int src, input int n, input int vin, input bit d,
                         input bit j, input bit ien, input bit poke);
    int len;
    int vc;
    logic [15:0] exp_w;
    len = 12 * (n + 1);
    vc  = d ? vin + 2048 : vin;
    vin_code = vc;
    clk_div = 5'(n); diff_mode = d; justify = j; irq_en = ien;
    start_sel = 2'(src);
    exp_w = expect_word(vin, d, j);
    fire(src);
    @(posedge clk);
    @(negedge clk);
    drop_pulses();
    chk(busy == 1'b1, "R2", $sformatf("busy after trigger src=%0d", src), busy, 1);
    chk(dac_code == 12'h800, "R10", "first trial", dac_code, 12'h800);
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      if (k == n + 1)
        chk(dac_code == ((vc >= 2048) ? 12'hC00 : 12'h400), "R10", "second trial",
            dac_code, (vc >= 2048) ? 12'hC00 : 12'h400);
      if (poke && k == len / 2) begin
        sw_start = 1'b1;
        chk(data_word == last_word, "R11", "word mid-conversion", data_word, last_word);
      end
      if (poke && k == len / 2 + 1) sw_start = 1'b0;
    end
    chk(busy == 1'b1, "R3", "busy at last cycle", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R3", "busy fall", busy, 0);
    chk(eoc_flag == 1'b1, "R4", "eoc set", eoc_flag, 1);
    chk(irq == ien, "R4", "irq follows enable", irq, ien);
    chk(data_word == exp_w, d ? "R6" : "R5", $sformatf("result vin=%0d j=%0d", vin, j),
        data_word, exp_w);
    if (j) chk(data_word[3:0] == 4'h0, "R7", "left low nibble", data_word[3:0], 0);
    if (poke) chk(eoc_flag == 1'b1 && busy == 1'b0, "R9", "retrigger ignored", busy, 0);
    last_word = exp_w;
    repeat (3) @(negedge clk);
    chk(eoc_flag == 1'b1, "R4", "eoc sticky", eoc_flag, 1);
    ext_start = 1'b0;
    clear_eoc();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy reset", busy, 0);
    chk(eoc_flag == 1'b0, "R1", "eoc reset", eoc_flag, 0);
    chk(irq == 1'b0, "R1", "irq reset", irq, 0);
    chk(data_word == 16'h0, "R1", "word reset", data_word, 0);
    chk(dac_code == 12'h0, "R1", "dac reset", dac_code, 0);
  endtask

  task automatic t_disabled;
    enable = 1'b0;
    start_sel = 2'd0;
    fire(0);
    @(negedge clk);
    drop_pulses();
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8", "busy while disabled", busy, 0);
    chk(eoc_flag == 1'b0, "R8", "eoc while disabled", eoc_flag, 0);
    chk(data_word == last_word, "R8", "word while disabled", data_word, last_word);
    enable = 1'b1;
  endtask

  task automatic t_wrong_source;
    start_sel = 2'd1;
    @(negedge clk);
    sw_start = 1'b1; tmr3_ovf = 1'b1; ext_start = 1'b1;
    @(negedge clk);
    drop_pulses();
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R2", "unselected sources", busy, 0);
    ext_start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_disabled();
    enable = 1'b1;
    convert(0, 0, 1234, 0, 0, 1, 0);
    convert(1, 3, 5000, 0, 0, 1, 0);      // R5 saturation high
    convert(2, 16, 0, 0, 1, 0, 0);        // R7 left, zero
    convert(3, 1, 3000, 0, 1, 1, 0);      // R2 external edge
    convert(0, 2, -700, 1, 0, 1, 0);      // R6 negative
    convert(1, 0, 2047, 1, 1, 0, 0);      // R6 max, left
    convert(2, 0, 9000, 1, 0, 1, 0);      // R6 saturate high
    convert(0, 1, -3000, 1, 0, 1, 0);     // R6 saturate low
    convert(0, 3, 931, 0, 0, 1, 1);       // R9 R11 retrigger mid-run
    t_wrong_source();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule